// File: doc/BRIEF.md
# Counted-Frame Serial Command Slave

This block is the serial front end of a 32-channel converter. A host opens a transfer by pulling the active-low frame sync low. That falling edge arms a bit counter. Command bits are then taken on falling edges of the serial clock, most significant bit first. The mode field at the head of the word sets how many bits the frame holds. Once that many bits have arrived, the frame is closed: the serial clock and any further sync activity have no effect until sync falls again after the frame has ended.

A finished command frame presents its decoded fields on the outputs: mode, calibration, offset select, channel address and, for writes, a 14-bit data word. A write frame also raises a one-cycle write strobe. A readback request latches the channel address on `rb_channel`. On the next sync falling edge the block loads the word that the channel storage returns on `rb_word`. During that frame the word is shifted out on `sdo`, and `sdo_drive` marks when the pin is actively driven. All serial inputs are oversampled by the system clock through a synchronizer chain.

Top module: `serial_cmd_slave`

## Requirements
- R1: After reset, all decoded field outputs are zero, `wr_stb` is low, `sdo_drive` is low and `rb_channel` is zero.
- R2: A frame begins only at a falling edge of `sync_n`. Serial clock pulses given before any such edge change no output.
- R3: Bits are sampled on falling edges of `sclk`, MSB first. The header is 10 bits in this order: mode[1:0], calibration, offset select, channel address[4:0] with A4 first, and one reserved bit. A write frame follows the header with 14 data bits, DB13 first.
- R4: Mode 2'b01 is a write. Its frame holds 24 bits. At its end the fields and `data` update, and `wr_stb` is high for exactly one system clock.
- R5: Every other mode code closes after 10 bits. The mode, calibration, offset-select and address outputs update, `data` keeps its value, and no strobe is raised.
- R6: While a frame is open, further falling edges of `sync_n` are ignored. The frame completes with its original bits.
- R7: Once a frame has its full bit count, further serial clocks change no output and raise no strobe until the next `sync_n` falling edge.
- R8: A finished mode 2'b10 frame places its address on `rb_channel`. The next `sync_n` falling edge loads the 14-bit `rb_word` into the output shifter.
- R9: In a readback frame, the first rising `sclk` edge sets `sdo_drive` and presents the MSB. Each later rising edge presents the next bit. `sdo_drive` clears on the 14th falling `sclk` edge.
- R10: During a readback frame, `sdi` is ignored. A readback frame changes none of the decoded field outputs and raises no strobe.
- R11: A `sync_n` falling edge after a completed frame always starts a new frame, even if the previous frame had no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame sync from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| rb_word | input | 14 | Word stored for the channel on `rb_channel` |
| sdo | output | 1 | Serial readback data, valid while `sdo_drive` is high |
| sdo_drive | output | 1 | High while the readback pin is driven, low for high impedance |
| rb_channel | output | 5 | Channel named by the last readback request |
| mode | output | 2 | Decoded mode field |
| cal | output | 1 | Decoded calibration bit |
| ofs_sel | output | 1 | Decoded offset-select bit |
| chan | output | 5 | Decoded channel address |
| data | output | 14 | Data word of the last write frame |
| wr_stb | output | 1 | One-cycle pulse at the end of a write frame |

## Verification
Command words are sent with every mode code. They use address and data patterns of all ones, single set bits at either end and alternating bits. This separates a bit-order or field-position error from a counting error, and a 24-bit close from a 10-bit close. Directed frames add extra clocks before any sync and after the count is reached, plus a sync pulse inside an open frame. These show whether framing follows the counter or the sync level. A readback is driven with `sdi` held high throughout. The bits sampled on `sdo` must match the stored word for the requested channel, and the driven window must close exactly at the 14th falling edge.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  localparam int unsigned HDR_BITS  = 10;
  localparam int unsigned WORD_BITS = 14;
  localparam int unsigned CHAN_BITS = 5;
  localparam int unsigned MODE_BITS = 2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_READ  = 2'b10,
    MODE_SPARE = 2'b11
  } cmd_mode_e;

  // Frame length in bits for a given mode code.
  function automatic int unsigned frame_len(input logic [1:0] m);
    return (m == MODE_WRITE) ? HDR_BITS + WORD_BITS : HDR_BITS;
  endfunction
endpackage

// File: rtl/scmd_edge.sv
module scmd_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/scmd_rx.sv
module scmd_rx
  import scmd_pkg::*;
#(
  parameter int unsigned HDR_W  = HDR_BITS,
  parameter int unsigned DATA_W = WORD_BITS,
  parameter int unsigned ADDR_W = CHAN_BITS,
  parameter int unsigned MODE_W = MODE_BITS,
  localparam int unsigned FRAME_W = HDR_W + DATA_W,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_sync_fall,
  input  logic              ev_sclk_fall,
  input  logic              din,
  output logic              busy,
  output logic              is_rb,
  output logic              cmd_done,
  output logic              rb_start,
  output logic              rb_end,
  output logic [MODE_W-1:0] mode_o,
  output logic              cal_o,
  output logic              osel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] rb_addr
);
  localparam int unsigned CAL_POS  = HDR_W - MODE_W - 1;
  localparam int unsigned OSEL_POS = HDR_W - MODE_W - 2;
  localparam int unsigned ADDR_TOP = HDR_W - MODE_W - 3;

  function automatic logic [MODE_W-1:0] hdr_mode(input logic [HDR_W-1:0] h);
    return h[HDR_W-1 -: MODE_W];
  endfunction
  function automatic logic [ADDR_W-1:0] hdr_addr(input logic [HDR_W-1:0] h);
    return h[ADDR_TOP -: ADDR_W];
  endfunction

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [MODE_W-1:0]  mode_seen_q;
  logic               busy_q, is_rb_q, rb_pend_q;
  logic               accept, bit_ev, hdr_end, wr_end;
  logic [HDR_W-1:0]   hdr;

  always_comb begin
    sh_n     = {sh_q[FRAME_W-2:0], din};
    cnt_n    = cnt_q + 1'b1;
    accept   = ev_sync_fall && !busy_q;
    bit_ev   = ev_sclk_fall && busy_q;
    hdr_end  = bit_ev && !is_rb_q && (cnt_n == CNT_W'(HDR_W))
               && (mode_seen_q != MODE_W'(MODE_WRITE));
    wr_end   = bit_ev && !is_rb_q && (cnt_n == CNT_W'(FRAME_W));
    cmd_done = hdr_end || wr_end;
    rb_end   = bit_ev && is_rb_q && (cnt_n == CNT_W'(DATA_W));
    rb_start = accept && rb_pend_q;
    hdr      = wr_end ? sh_n[FRAME_W-1 -: HDR_W] : sh_n[HDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      is_rb_q     <= 1'b0;
      rb_pend_q   <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      mode_seen_q <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      is_rb_q   <= rb_pend_q;
      rb_pend_q <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else if (bit_ev) begin
      cnt_q <= cnt_n;
      if (!is_rb_q) sh_q <= sh_n;
      if (!is_rb_q && cnt_n == CNT_W'(MODE_W)) mode_seen_q <= sh_n[MODE_W-1:0];
      if (cmd_done || rb_end) busy_q <= 1'b0;
      if (cmd_done && hdr_mode(hdr) == MODE_W'(MODE_READ)) rb_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o  <= '0;
      cal_o   <= 1'b0;
      osel_o  <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      wr_stb  <= 1'b0;
      rb_addr <= '0;
    end else begin
      wr_stb <= wr_end;
      if (cmd_done) begin
        mode_o <= hdr_mode(hdr);
        cal_o  <= hdr[CAL_POS];
        osel_o <= hdr[OSEL_POS];
        addr_o <= hdr_addr(hdr);
        if (hdr_mode(hdr) == MODE_W'(MODE_READ)) rb_addr <= hdr_addr(hdr);
      end
      if (wr_end) data_o <= sh_n[DATA_W-1:0];
    end
  end

  assign busy  = busy_q;
  assign is_rb = is_rb_q;
endmodule

// File: rtl/scmd_tx.sv
module scmd_tx #(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              rb_active,
  input  logic              ev_rise,
  input  logic              stop,
  output logic              sdo,
  output logic              drive
);
  logic [DATA_W-1:0] sh_q;
  logic              started_q, drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      started_q <= 1'b0;
      drive_q   <= 1'b0;
    end else if (load) begin
      sh_q      <= load_word;
      started_q <= 1'b0;
      drive_q   <= 1'b0;
    end else if (stop) begin
      started_q <= 1'b0;
      drive_q   <= 1'b0;
    end else if (ev_rise && rb_active) begin
      if (!started_q) begin
        started_q <= 1'b1;
        drive_q   <= 1'b1;
      end else begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdo   = drive_q & sh_q[DATA_W-1];
  assign drive = drive_q;
endmodule

// File: rtl/serial_cmd_slave.sv
module serial_cmd_slave
  import scmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = WORD_BITS,
  parameter int unsigned ADDR_W      = CHAN_BITS,
  parameter int unsigned MODE_W      = MODE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rb_word,
  output logic              sdo,
  output logic              sdo_drive,
  output logic [ADDR_W-1:0] rb_channel,
  output logic [MODE_W-1:0] mode,
  output logic              cal,
  output logic              ofs_sel,
  output logic [ADDR_W-1:0] chan,
  output logic [DATA_W-1:0] data,
  output logic              wr_stb
);
  localparam int unsigned N_IN = 3;   // 0: sdi, 1: sclk, 2: sync_n

  logic [N_IN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  assign pin_raw = {sync_n, sclk, sdi};

  for (genvar g = 0; g < N_IN; g++) begin : g_pin
    scmd_edge #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(g == 2)
    ) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_raw[g]),
      .level(pin_lvl[g]),
      .rise (pin_rise[g]),
      .fall (pin_fall[g])
    );
  end

  // Named internal events for the checker.
  logic ev_sync_fall, ev_sclk_fall, ev_sclk_rise, sdi_s;
  logic frame_busy, frame_is_rb, cmd_done, rb_start, rb_end;
  assign ev_sync_fall = pin_fall[2];
  assign ev_sclk_fall = pin_fall[1];
  assign ev_sclk_rise = pin_rise[1];
  assign sdi_s        = pin_lvl[0];

  logic sig_unused;
  assign sig_unused = &{pin_lvl[2:1], pin_rise[2], pin_rise[0], pin_fall[0]};

  scmd_rx #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .MODE_W(MODE_W)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_sync_fall(ev_sync_fall),
    .ev_sclk_fall(ev_sclk_fall),
    .din         (sdi_s),
    .busy        (frame_busy),
    .is_rb       (frame_is_rb),
    .cmd_done    (cmd_done),
    .rb_start    (rb_start),
    .rb_end      (rb_end),
    .mode_o      (mode),
    .cal_o       (cal),
    .osel_o      (ofs_sel),
    .addr_o      (chan),
    .data_o      (data),
    .wr_stb      (wr_stb),
    .rb_addr     (rb_channel)
  );

  scmd_tx #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rb_start),
    .load_word(rb_word),
    .rb_active(frame_busy && frame_is_rb),
    .ev_rise  (ev_sclk_rise),
    .stop     (rb_end),
    .sdo      (sdo),
    .drive    (sdo_drive)
  );
endmodule

// File: rtl/scmd_checker.sv
module scmd_checker #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [MODE_W-1:0] mode,
  input logic              cal,
  input logic              ofs_sel,
  input logic [ADDR_W-1:0] chan,
  input logic [DATA_W-1:0] data,
  input logic              sdo,
  input logic              sdo_drive,
  input logic              ev_sync_fall,
  input logic              ev_sclk_rise,
  input logic              frame_busy,
  input logic              cmd_done,
  input logic              rb_end
);
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_strobe_write_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (mode == MODE_W'(1)));

  assert_data_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> wr_stb);

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |=> $stable({mode, cal, ofs_sel, chan}));

  assert_frame_opens_on_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_busy) |-> $past(ev_sync_fall));

  assert_drive_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_drive) |-> $past(ev_sclk_rise));

  assert_drive_off_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_drive) |-> $past(rb_end));

  assert_sdo_moves_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_drive && $past(sdo_drive) && !$stable(sdo)) |-> $past(ev_sclk_rise));
endmodule

bind serial_cmd_slave scmd_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .MODE_W(MODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_stb      (wr_stb),
  .mode        (mode),
  .cal         (cal),
  .ofs_sel     (ofs_sel),
  .chan        (chan),
  .data        (data),
  .sdo         (sdo),
  .sdo_drive   (sdo_drive),
  .ev_sync_fall(ev_sync_fall),
  .ev_sclk_rise(ev_sclk_rise),
  .frame_busy  (frame_busy),
  .cmd_done    (cmd_done),
  .rb_end      (rb_end)
);

// File: tb/serial_cmd_slave_tb.sv
module serial_cmd_slave_tb;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [13:0] rb_word;
  logic        sdo, sdo_drive, cal, ofs_sel, wr_stb;
  logic [4:0]  rb_channel, chan;
  logic [1:0]  mode;
  logic [13:0] data;

  int checks = 0, errors = 0, strobes = 0, long_strobes = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
    .rb_word(rb_word), .sdo(sdo), .sdo_drive(sdo_drive), .rb_channel(rb_channel),
    .mode(mode), .cal(cal), .ofs_sel(ofs_sel), .chan(chan), .data(data),
    .wr_stb(wr_stb)
  );

  // Channel storage model: word depends on the requested channel.
  function automatic logic [13:0] stored(input logic [4:0] a);
    return {a, ~a, 4'b1001};
  endfunction
  assign rb_word = stored(rb_channel);

  logic prev_stb = 1'b0;
  always @(posedge clk) begin
    if (wr_stb) strobes++;
    if (wr_stb && prev_stb) long_strobes++;
    prev_stb <= wr_stb;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdi = b; sclk = 1'b1; wait_half();
    sclk = 1'b0; wait_half();
  endtask

  // Send n bits MSB first; optional sync glitch before bit index glitch_at;
  // extra clocks after the frame while sync stays low.
  task automatic send(input logic [23:0] bits, input int n, input int glitch_at, input int extra);
    sync_n = 1'b0; wait_half();
    for (int i = n - 1; i >= 0; i--) begin
      if ((n - 1 - i) == glitch_at) begin
        sync_n = 1'b1; wait_half(); sync_n = 1'b0; wait_half();
      end
      pulse(bits[i]);
    end
    for (int k = 0; k < extra; k++) pulse(k[0]);
    sync_n = 1'b1; wait_half(); wait_half();
  endtask

  function automatic logic [9:0] hdr(input logic [1:0] m, input logic c, input logic o, input logic [4:0] a);
    return {m, c, o, a, 1'b0};
  endfunction

  task automatic read_back(output logic [13:0] got, output int drv_ok);
    drv_ok = 1;
    sync_n = 1'b0; wait_half();
    if (sdo_drive !== 1'b0) drv_ok = 0;
    for (int i = 13; i >= 0; i--) begin
      sdi = 1'b1; sclk = 1'b1; wait_half();
      got[i] = sdo;
      if (sdo_drive !== 1'b1) drv_ok = 0;
      sclk = 1'b0; wait_half();
    end
    sync_n = 1'b1; wait_half();
  endtask

  // mode, cal, osel, addr, data
  localparam logic [22:0] VEC [0:5] = '{
    {2'b01, 1'b1, 1'b0, 5'h1F, 14'h3FFF},
    {2'b01, 1'b0, 1'b1, 5'h00, 14'h2A55},
    {2'b00, 1'b1, 1'b1, 5'h0A, 14'h0000},
    {2'b01, 1'b0, 1'b0, 5'h15, 14'h0001},
    {2'b11, 1'b0, 1'b1, 5'h11, 14'h0000},
    {2'b01, 1'b1, 1'b1, 5'h02, 14'h2000}
  };

  initial begin
    logic [13:0] exp_data, got;
    int s0, drv_ok;
    exp_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 fields", {mode, cal, ofs_sel, chan, data}, 0);
    chk("R1 strobe/drive", {wr_stb, sdo_drive, rb_channel}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: clocks with no sync edge
    for (int k = 0; k < 26; k++) pulse(1'b1);
    chk("R2 no frame", {mode, cal, ofs_sel, chan, data}, 0);
    chk("R2 no strobe", strobes, 0);

    // R3 R4 R5 R11: table walk
    for (int v = 0; v < 6; v++) begin
      logic [1:0] m; logic c, o; logic [4:0] a; logic [13:0] d;
      {m, c, o, a, d} = VEC[v];
      s0 = strobes;
      if (m == 2'b01) begin
        send({hdr(m, c, o, a), d}, 24, -1, 0);
        exp_data = d;
      end else begin
        send({14'b0, hdr(m, c, o, a)}, 10, -1, 0);
      end
      chk("R3 fields", {mode, cal, ofs_sel, chan}, {m, c, o, a});
      chk(m == 2'b01 ? "R4 data" : "R5 data kept", data, exp_data);
      chk(m == 2'b01 ? "R4 strobe" : "R5 no strobe R11", strobes - s0, (m == 2'b01) ? 1 : 0);
    end
    chk("R4 strobe width", long_strobes, 0);

    // R6: sync pulse inside an open write frame
    s0 = strobes;
    send({hdr(2'b01, 1'b0, 1'b1, 5'h0C), 14'h1234}, 24, 7, 0);
    chk("R6 fields", {mode, cal, ofs_sel, chan}, {2'b01, 1'b0, 1'b1, 5'h0C});
    chk("R6 data", data, 14'h1234);
    chk("R6 strobe", strobes - s0, 1);

    // R7: extra clocks after the count is reached
    s0 = strobes;
    send({hdr(2'b01, 1'b1, 1'b0, 5'h07), 14'h0F0F}, 24, -1, 12);
    chk("R7 data", data, 14'h0F0F);
    chk("R7 fields", {mode, cal, ofs_sel, chan}, {2'b01, 1'b1, 1'b0, 5'h07});
    chk("R7 strobe", strobes - s0, 1);
    s0 = strobes;
    send({14'b0, hdr(2'b11, 1'b0, 1'b0, 5'h1B)}, 10, -1, 14);
    chk("R7 short frame", {mode, cal, ofs_sel, chan, data}, {2'b11, 1'b0, 1'b0, 5'h1B, 14'h0F0F});
    chk("R7 no strobe", strobes - s0, 0);

    // R8: readback request
    s0 = strobes;
    send({14'b0, hdr(2'b10, 1'b1, 1'b0, 5'h13)}, 10, -1, 0);
    chk("R8 channel", rb_channel, 5'h13);
    chk("R8 fields", {mode, cal, chan}, {2'b10, 1'b1, 5'h13});
    chk("R8 no strobe", strobes - s0, 0);

    // R9 R10: readback frame with sdi held high
    read_back(got, drv_ok);
    chk("R9 word", got, stored(5'h13));
    chk("R9 drive window", drv_ok, 1);
    chk("R9 released", sdo_drive, 1'b0);
    chk("R10 fields", {mode, cal, ofs_sel, chan, data}, {2'b10, 1'b1, 1'b0, 5'h13, 14'h0F0F});
    chk("R10 no strobe", strobes - s0, 0);

    // R11: frame after readback starts fresh
    s0 = strobes;
    send({hdr(2'b01, 1'b0, 1'b0, 5'h1E), 14'h3001}, 24, -1, 0);
    chk("R11 data", data, 14'h3001);
    chk("R11 strobe", strobes - s0, 1);
    chk("R11 no drive", sdo_drive, 1'b0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule